// File: doc/BRIEF.md
# Two-Phase Call Router for a Shared Subroutine

This block lets several clients share one subroutine unit over two-phase (transition) signalling. Each client owns a request line and an acknowledge line. The subroutine sees one request/acknowledge pair. Any change of level on a line, rising or falling, is one event. There is no return-to-zero phase. When a client's request line changes, the router toggles the subroutine request and records which client made the call. It also captures that client's operand bundle and drives it to the subroutine. When the subroutine's acknowledge line changes, the router toggles the acknowledge line of the recorded client and no other.

The clients must not call at the same time, so the router has no arbiter. A call that overlaps another call, two clients that toggle in the same cycle, or an acknowledge that arrives with no call open is a protocol violation. Each of these sets a sticky error flag. The router is modelled synchronously: every toggling input is compared with its value one clock earlier, and all outputs are registered.

Top module: `call_router`

## Requirements
- R1: While `rst` is high and in the cycle after it, `sub_req`, every `cli_ack` bit, `sub_data` and `proto_err` are all 0, and no call is open.
- R2: With no call open, a change of one client's request line, rising or falling, causes `sub_req` to change level on the first rising clock edge that samples the new level.
- R3: On that same edge `sub_data` takes the calling client's bundle. `sub_data` then holds that value, even if the client's data inputs change, until the call returns.
- R4: A change of `sub_ack` while a call is open toggles the `cli_ack` bit of the calling client on the first edge that samples it. All other `cli_ack` bits keep their level.
- R5: No `cli_ack` bit changes unless a `sub_ack` change was sampled while a call was open.
- R6: A client request change sampled while a call is open sets `proto_err`. `sub_req` does not change, and the open call is still returned to its original client.
- R7: A `sub_ack` change sampled with no call open sets `proto_err` and leaves every `cli_ack` bit unchanged.
- R8: Once set, `proto_err` stays 1 until reset.
- R9: Request changes from two or more clients sampled on the same edge with no call open set `proto_err`. Neither request is forwarded, so `sub_req` does not change.
- R10: While no protocol error has occurred and no call is open, `sub_req` equals the XOR of all client request levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| cli_req | input | N_CLI | Client request lines, one event per level change |
| cli_ack | output | N_CLI | Client acknowledge lines, toggled on call return |
| cli_data | input | N_CLI*DW | Client operand bundles; client k occupies bits [k*DW +: DW] |
| sub_req | output | 1 | Request line to the shared subroutine |
| sub_ack | input | 1 | Acknowledge line from the shared subroutine |
| sub_data | output | DW | Operand bundle of the calling client, held for the whole call |
| proto_err | output | 1 | Sticky protocol-violation flag |

## Verification
The stimulus table walks calls from both clients through both polarities of every line. This catches a design that reacts to only one edge direction or that returns an acknowledge to the wrong client. Directed tests change the caller's data during an open call, to catch a transparent data mux. They also issue an overlapping request, a stray acknowledge and a same-cycle collision. A design that forwards or returns on these events shows a moved `sub_req` or `cli_ack`, or leaves `proto_err` low. The overlap test also checks that the open call still returns to its first owner. This catches a design that lets the intruding client take ownership.

// File: rtl/call_pkg.sv
package call_pkg;

    localparam int CLI_DEFAULT = 2;
    localparam int DW_DEFAULT  = 32;

    // Classification of the request events sampled on one edge
    typedef enum logic [1:0] {
        REQ_NONE = 2'd0,
        REQ_CALL = 2'd1,
        REQ_BAD  = 2'd2
    } req_kind_t;

    function automatic req_kind_t classify_req(input int n_events, input logic open_call);
        if (n_events == 0)
            return REQ_NONE;
        else if (n_events == 1 && !open_call)
            return REQ_CALL;
        else
            return REQ_BAD;
    endfunction

endpackage

// File: rtl/tog_edge.sv
module tog_edge #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lines,
    output logic [W-1:0] evt
);
    logic [W-1:0] seen_q;

    always_ff @(posedge clk) begin
        if (rst) seen_q <= '0;
        else     seen_q <= lines;
    end

    // An event is any difference from the level sampled last cycle
    assign evt = lines ^ seen_q;
endmodule

// File: rtl/bundle_mux.sv
module bundle_mux #(
    parameter int N  = 2,
    parameter int DW = 32,
    parameter int IW = 1
) (
    input  logic [N-1:0]    sel_oh,
    input  logic [N*DW-1:0] bundles,
    output logic [IW-1:0]   idx,
    output logic [DW-1:0]   picked
);
    logic [DW-1:0] slot [N];

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_slice
            assign slot[g] = bundles[g*DW +: DW];
        end
    endgenerate

    always_comb begin
        idx    = '0;
        picked = '0;
        for (int k = 0; k < N; k++) begin
            if (sel_oh[k]) begin
                idx    = IW'(k);
                picked = picked | slot[k];
            end
        end
    end
endmodule

// File: rtl/call_router.sv
module call_router
    import call_pkg::*;
#(
    parameter int N_CLI = CLI_DEFAULT,
    parameter int DW    = DW_DEFAULT
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_CLI-1:0]    cli_req,
    output logic [N_CLI-1:0]    cli_ack,
    input  logic [N_CLI*DW-1:0] cli_data,
    output logic                sub_req,
    input  logic                sub_ack,
    output logic [DW-1:0]       sub_data,
    output logic                proto_err
);
    localparam int IW = (N_CLI > 1) ? $clog2(N_CLI) : 1;

    logic [N_CLI-1:0] req_evt;
    logic             ack_evt;
    logic [IW-1:0]    req_idx;
    logic [DW-1:0]    req_bundle;
    logic             open_q;
    logic [IW-1:0]    owner_q;
    req_kind_t        kind;

    tog_edge #(.W(N_CLI)) u_req_edge (
        .clk   (clk),
        .rst   (rst),
        .lines (cli_req),
        .evt   (req_evt)
    );

    tog_edge #(.W(1)) u_ack_edge (
        .clk   (clk),
        .rst   (rst),
        .lines (sub_ack),
        .evt   (ack_evt)
    );

    bundle_mux #(.N(N_CLI), .DW(DW), .IW(IW)) u_mux (
        .sel_oh  (req_evt),
        .bundles (cli_data),
        .idx     (req_idx),
        .picked  (req_bundle)
    );

    assign kind = classify_req($countones(req_evt), open_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q    <= 1'b0;
            owner_q   <= '0;
            sub_req   <= 1'b0;
            sub_data  <= '0;
            cli_ack   <= '0;
            proto_err <= 1'b0;
        end else begin
            // Return path: steer the acknowledge to the recorded caller
            if (ack_evt && open_q) begin
                cli_ack[owner_q] <= ~cli_ack[owner_q];
                open_q           <= 1'b0;
            end
            // Call path: merge the single request onto the subroutine line
            if (kind == REQ_CALL) begin
                sub_req  <= ~sub_req;
                owner_q  <= req_idx;
                sub_data <= req_bundle;
                open_q   <= 1'b1;
            end
            if (kind == REQ_BAD || (ack_evt && !open_q))
                proto_err <= 1'b1;
        end
    end

    // R4: at most one client acknowledge moves per cycle
    assert_single_return_R4: assert property (@(posedge clk) disable iff (rst)
        $countones(cli_ack ^ $past(cli_ack)) <= 1);

    // R5: a client acknowledge moves only when the subroutine answered an open call
    assert_ack_needs_call_R5: assert property (@(posedge clk) disable iff (rst)
        (cli_ack != $past(cli_ack)) |-> ($past(ack_evt) && $past(open_q)));

    // R2: a forwarded request always leaves a call open
    assert_req_opens_call_R2: assert property (@(posedge clk) disable iff (rst)
        (sub_req != $past(sub_req)) |-> open_q);

    // R3: the operand bundle is frozen while the call stays open
    assert_bundle_held_R3: assert property (@(posedge clk) disable iff (rst)
        (open_q && $past(open_q)) |-> $stable(sub_data));

    // R8: the error flag never clears without reset
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        $past(proto_err) |-> proto_err);

    // R6/R9: an illegal request pattern never moves the subroutine request
    assert_bad_req_blocked_R6: assert property (@(posedge clk) disable iff (rst)
        (kind == REQ_BAD) |=> $stable(sub_req));
endmodule

// File: tb/tb_call_router.sv
module tb_call_router;
    localparam int N  = 2;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  cli_req = '0;
    logic [N-1:0]  cli_ack;
    logic [N*DW-1:0] cli_data = '0;
    logic          sub_req;
    logic          sub_ack = 1'b0;
    logic [DW-1:0] sub_data;
    logic          proto_err;

    int checks   = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    call_router #(.N_CLI(N), .DW(DW)) dut (
        .clk(clk), .rst(rst), .cli_req(cli_req), .cli_ack(cli_ack),
        .cli_data(cli_data), .sub_req(sub_req), .sub_ack(sub_ack),
        .sub_data(sub_data), .proto_err(proto_err)
    );

    // Vector: [9]=op (0 call, 1 return), [8]=client, [7:0]=operand
    localparam logic [9:0] VEC [10] = '{
        {1'b0, 1'b0, 8'hA5}, {1'b1, 1'b0, 8'h00},
        {1'b0, 1'b1, 8'h3C}, {1'b1, 1'b0, 8'h00},
        {1'b0, 1'b1, 8'hFF}, {1'b1, 1'b0, 8'h00},
        {1'b0, 1'b0, 8'h01}, {1'b1, 1'b0, 8'h00},
        {1'b0, 1'b0, 8'h80}, {1'b1, 1'b0, 8'h00}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        cli_req = '0; sub_ack = 1'b0;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        @(negedge clk);
    endtask

    logic        e_req;
    logic [N-1:0] e_ack;
    int          owner;

    initial begin
        #(5ns * 20000);
        failures++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1 reset state
        @(negedge clk); @(negedge clk);
        chk(sub_req == 0 && cli_ack == 0 && sub_data == 0 && proto_err == 0,
            "R1 reset", {sub_req, cli_ack, proto_err}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(sub_req == 0 && cli_ack == 0 && proto_err == 0, "R1 after reset",
            {sub_req, cli_ack, proto_err}, 0);

        e_req = 0; e_ack = '0; owner = 0;
        for (int v = 0; v < 10; v++) begin
            logic [9:0] w;
            w = VEC[v];
            if (!w[9]) begin
                owner = int'(w[8]);
                cli_data[owner*DW +: DW] = w[7:0];
                cli_req[owner] = ~cli_req[owner];
                e_req = ~e_req;
                @(negedge clk);
                chk(sub_req == e_req, "R2 request forwarded", sub_req, e_req);
                chk(sub_data == w[7:0], "R3 bundle captured", sub_data, w[7:0]);
                chk(cli_ack == e_ack, "R5 no early ack", cli_ack, e_ack);
            end else begin
                sub_ack = ~sub_ack;
                e_ack[owner] = ~e_ack[owner];
                @(negedge clk);
                chk(cli_ack == e_ack, "R4 ack to caller only", cli_ack, e_ack);
                chk(sub_req == ^cli_req, "R10 merge parity", sub_req, ^cli_req);
                chk(proto_err == 0, "R8 no error in legal flow", proto_err, 0);
            end
        end

        // R3: caller data changes during open call
        cli_data[DW +: DW] = 8'h5A;
        cli_req[1] = ~cli_req[1];
        e_req = ~e_req;
        @(negedge clk);
        cli_data[DW +: DW] = 8'hC3;
        @(negedge clk); @(negedge clk);
        chk(sub_data == 8'h5A, "R3 bundle held", sub_data, 8'h5A);

        // R6: overlapping request from client 0 while client 1 owns the call
        cli_req[0] = ~cli_req[0];
        @(negedge clk);
        chk(proto_err == 1, "R6 overlap flags error", proto_err, 1);
        chk(sub_req == e_req, "R6 overlap not forwarded", sub_req, e_req);
        sub_ack = ~sub_ack;
        e_ack[1] = ~e_ack[1];
        @(negedge clk);
        chk(cli_ack == e_ack, "R6 return to original owner", cli_ack, e_ack);
        @(negedge clk); @(negedge clk);
        chk(proto_err == 1, "R8 error sticky", proto_err, 1);

        // R7: stray acknowledge
        do_reset();
        chk(proto_err == 0, "R1 error cleared by reset", proto_err, 0);
        sub_ack = ~sub_ack;
        @(negedge clk);
        chk(proto_err == 1, "R7 stray ack flags error", proto_err, 1);
        chk(cli_ack == 0, "R7 stray ack not returned", cli_ack, 0);

        // R9: simultaneous requests
        do_reset();
        cli_req = 2'b11;
        @(negedge clk);
        chk(proto_err == 1, "R9 collision flags error", proto_err, 1);
        chk(sub_req == 0, "R9 collision not forwarded", sub_req, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule